// File: doc/BRIEF.md
# Timebase Timer with Watchdog

This block runs a 13-bit up-counter that advances once every 32 input clocks. Out of that one count it derives three services: a periodic timebase event with a selectable length of 250 or 500 counter steps, a watchdog that software must keep refreshing, and an 8-bit input capture that records the low byte of the counter when an external pin rises.

Software controls the block through a byte-wide port with two addresses. Address 0 is the control and status byte, which can be written and read. Address 1 is the capture byte, which can only be read. The block drives two interrupt lines, one for the timebase and one for the capture, and a watchdog reset request. Acting on that request belongs to the rest of the chip. A halt input freezes all counting.

Top module: `tbw_top`

## Requirements
- R1: The counter is 13 bits wide and counts up by exactly one every 32 clocks while halt_i is low. Its low 8 bits are visible through the capture byte.
- R2: Control bit 0 selects the timebase period: 250 counter steps (8000 clocks) when it is 0, and 500 counter steps (16000 clocks) when it is 1.
- R3: The timebase flag (control bit 2) is set at the end of every period. tb_irq_o is high while the flag and the timebase enable (control bit 1) are both 1. A read of address 0 clears the flag, unless the flag is set again in that same cycle.
- R4: The watchdog is active only while control bit 5 is 1. While that bit is 0, wdg_rst_o stays low.
- R5: Writing 1 to control bit 6 sets the refresh bit. Writing 0 to it has no effect. Hardware clears the refresh bit at the end of each timebase period. If the watchdog is enabled and the refresh bit is already clear when a period ends, wdg_rst_o pulses high for exactly one cycle, in the cycle after that period end.
- R6: pin_cap_i passes through a two-flop synchroniser. On its synchronised rising edge, the block copies the low byte of the counter into the capture byte and sets the capture flag (control bit 4). cap_irq_o is high while that flag and the capture enable (control bit 3) are both 1.
- R7: Writes cannot change the capture flag. A read of address 1 clears it, unless a new edge sets it again in that same cycle.
- R8: While halt_i is high, the counter, the prescaler and the period count all hold their values. A capture taken during halt therefore returns the frozen count.
- R9: After reset, every control bit, both flags, the capture byte and the counter are 0, and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Freezes counting while high |
| pin_cap_i | input | 1 | Asynchronous capture trigger pin |
| reg_sel_i | input | 1 | Register address: 0 selects control, 1 selects capture |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe; the clear-on-read side effects happen on this |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| tb_irq_o | output | 1 | Timebase interrupt |
| cap_irq_o | output | 1 | Capture interrupt |
| wdg_rst_o | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
A wrong prescaler or counter state shows up at the ports in two places: in the low byte returned by the next capture, and as a timebase interrupt that arrives one period early or late. A stuck refresh bit can hide a missing refresh for a whole period, or it can raise a false reset request one cycle after a period end. Every output and the read data are therefore compared with an independent model on every clock. On top of that, directed checks measure the spacing between interrupts and between captured counts, so an error in the counting rate is caught within one period.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int unsigned CNT_W  = 13;
  localparam int unsigned CAP_W  = 8;
  // control byte bit positions
  localparam int unsigned B_TBSEL = 0;
  localparam int unsigned B_TBIE  = 1;
  localparam int unsigned B_TBF   = 2;
  localparam int unsigned B_CAPIE = 3;
  localparam int unsigned B_CAPF  = 4;
  localparam int unsigned B_WEN   = 5;
  localparam int unsigned B_WDLY  = 6;
endpackage

// File: rtl/tbw_timebase.sv
module tbw_timebase #(
  parameter int unsigned PRESC = 32,
  parameter int unsigned PER_A = 250,
  parameter int unsigned PER_B = 500,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             sel_long_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o
);
  localparam int unsigned PS_W  = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int unsigned PER_W = $clog2(PER_B + 1);

  logic [PS_W-1:0]  psc_q;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] lim;
  logic             tick;

  assign tick         = !halt_i && (psc_q == PS_W'(PRESC - 1));
  assign lim          = sel_long_i ? PER_W'(PER_B - 1) : PER_W'(PER_A - 1);
  // >= so that shortening the period mid-way still ends it
  assign period_end_o = tick && (per_q >= lim);
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      per_q <= '0;
      cnt_q <= '0;
    end else if (!halt_i) begin
      psc_q <= (psc_q == PS_W'(PRESC - 1)) ? '0 : psc_q + 1'b1;
      if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        per_q <= period_end_o ? '0 : per_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbw_capture.sv
module tbw_capture #(
  parameter int unsigned CAP_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CAP_W-1:0] cnt_lo_i,
  output logic             edge_o,
  output logic [CAP_W-1:0] cap_o
);
  logic [SYNC:0] sh_q;

  assign edge_o = sh_q[SYNC-1] && !sh_q[SYNC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cap_o <= '0;
    end else begin
      sh_q <= {sh_q[SYNC-1:0], pin_i};
      if (edge_o) cap_o <= cnt_lo_i;
    end
  end
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic refresh_i,
  input  logic period_end_i,
  output logic dly_o,
  output logic rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= period_end_i && en_i && !dly_o;
      if (refresh_i)         dly_o <= 1'b1;
      else if (period_end_i) dly_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tbw_top.sv
module tbw_top
  import tbw_pkg::*;
#(
  parameter int unsigned PRESC = 32,
  parameter int unsigned PER_A = 250,
  parameter int unsigned PER_B = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       pin_cap_i,
  input  logic       reg_sel_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       tb_irq_o,
  output logic       cap_irq_o,
  output logic       wdg_rst_o
);
  logic [CNT_W-1:0] cnt;
  logic [CAP_W-1:0] cap_val;
  logic period_end, cap_edge, wdg_dly;
  logic tb_sel_q, tb_ie_q, cap_ie_q, wdg_en_q, tb_flag_q, cap_flag_q;
  logic wr_ctl, rd_ctl, rd_cap;

  assign wr_ctl = reg_we_i && !reg_sel_i;
  assign rd_ctl = reg_re_i && !reg_sel_i;
  assign rd_cap = reg_re_i &&  reg_sel_i;

  tbw_timebase #(.PRESC(PRESC), .PER_A(PER_A), .PER_B(PER_B), .CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .halt_i,
    .sel_long_i   (tb_sel_q),
    .cnt_o        (cnt),
    .period_end_o (period_end)
  );

  tbw_capture #(.CAP_W(CAP_W), .SYNC(2)) u_cap (
    .clk_i, .rst_ni,
    .pin_i    (pin_cap_i),
    .cnt_lo_i (cnt[CAP_W-1:0]),
    .edge_o   (cap_edge),
    .cap_o    (cap_val)
  );

  tbw_watchdog u_wdg (
    .clk_i, .rst_ni,
    .en_i         (wdg_en_q),
    .refresh_i    (wr_ctl && reg_wdata_i[B_WDLY]),
    .period_end_i (period_end),
    .dly_o        (wdg_dly),
    .rst_req_o    (wdg_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_sel_q   <= 1'b0;
      tb_ie_q    <= 1'b0;
      cap_ie_q   <= 1'b0;
      wdg_en_q   <= 1'b0;
      tb_flag_q  <= 1'b0;
      cap_flag_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        tb_sel_q <= reg_wdata_i[B_TBSEL];
        tb_ie_q  <= reg_wdata_i[B_TBIE];
        cap_ie_q <= reg_wdata_i[B_CAPIE];
        wdg_en_q <= reg_wdata_i[B_WEN];
      end
      if (period_end)  tb_flag_q <= 1'b1;
      else if (rd_ctl) tb_flag_q <= 1'b0;
      if (cap_edge)    cap_flag_q <= 1'b1;
      else if (rd_cap) cap_flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o = cap_val;
    end else begin
      reg_rdata_o[B_TBSEL] = tb_sel_q;
      reg_rdata_o[B_TBIE]  = tb_ie_q;
      reg_rdata_o[B_TBF]   = tb_flag_q;
      reg_rdata_o[B_CAPIE] = cap_ie_q;
      reg_rdata_o[B_CAPF]  = cap_flag_q;
      reg_rdata_o[B_WEN]   = wdg_en_q;
      reg_rdata_o[B_WDLY]  = wdg_dly;
    end
  end

  assign tb_irq_o  = tb_flag_q && tb_ie_q;
  assign cap_irq_o = cap_flag_q && cap_ie_q;
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        halt_i,
  input logic        reg_sel_i,
  input logic        reg_we_i,
  input logic        reg_re_i,
  input logic        wdg_rst_o,
  input logic [12:0] cnt,
  input logic        period_end,
  input logic        cap_edge,
  input logic        tb_flag_q,
  input logic        cap_flag_q,
  input logic        wdg_en_q
);
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> cnt == $past(cnt) + 13'd1);
  p_tbf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> tb_flag_q);
  p_wdg_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |-> $past(wdg_en_q));
  p_wdg_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |=> !wdg_rst_o);
  p_capf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_edge |=> cap_flag_q);
  p_capf_nowrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !cap_edge && !(reg_re_i && reg_sel_i)) |=> cap_flag_q == $past(cap_flag_q));
  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(cnt));
endmodule

bind tbw_top tbw_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_i     (halt_i),
  .reg_sel_i  (reg_sel_i),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .wdg_rst_o  (wdg_rst_o),
  .cnt        (cnt),
  .period_end (period_end),
  .cap_edge   (cap_edge),
  .tb_flag_q  (tb_flag_q),
  .cap_flag_q (cap_flag_q),
  .wdg_en_q   (wdg_en_q)
);

// File: tb/sim_tbw_top.sv
`timescale 1ns/1ps
module sim_tbw_top;
  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, pin = 1'b0;
  logic sel = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic tb_irq, cap_irq, wdg_rst;

  int total = 0, bad = 0, cyc = 0, pulses = 0;
  int rise_t[$];
  logic tb_prev = 1'b0;

  // behavioural reference state
  int m_ps, m_per, m_cnt, m_capr;
  bit m_tbf, m_capf, m_rstp, m_dly, m_tbsel, m_tbie, m_capie, m_wen, m_s1, m_s2, m_s3;

  always #10 clk = ~clk;

  tbw_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .pin_cap_i(pin),
    .reg_sel_i(sel), .reg_we_i(we), .reg_re_i(re), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .tb_irq_o(tb_irq), .cap_irq_o(cap_irq), .wdg_rst_o(wdg_rst)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ps = 0; m_per = 0; m_cnt = 0; m_capr = 0;
      {m_tbf, m_capf, m_rstp, m_dly, m_tbsel, m_tbie, m_capie, m_wen, m_s1, m_s2, m_s3} = '0;
    end else begin
      bit tick, pend, edg;
      int lim;
      tick = !halt && (m_ps == 31);
      lim  = m_tbsel ? 500 : 250;
      pend = tick && (m_per >= lim - 1);
      edg  = m_s2 && !m_s3;
      m_rstp = pend && m_wen && !m_dly;
      if (we && !sel && wd[6]) m_dly = 1; else if (pend) m_dly = 0;
      if (edg) m_capr = m_cnt % 256;
      if (edg) m_capf = 1; else if (re && sel) m_capf = 0;
      if (pend) m_tbf = 1; else if (re && !sel) m_tbf = 0;
      if (we && !sel) begin
        m_tbsel = wd[0]; m_tbie = wd[1]; m_capie = wd[3]; m_wen = wd[5];
      end
      if (tick) begin
        m_per = pend ? 0 : m_per + 1;
        m_cnt = (m_cnt + 1) % 8192;
      end
      if (!halt) m_ps = (m_ps + 1) % 32;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_rd;
      exp_rd = sel ? 8'(m_capr)
                   : {1'b0, m_dly, m_wen, m_capf, m_capie, m_tbf, m_tbie, m_tbsel};
      chk(tb_irq  == (m_tbf && m_tbie),  "R3 tb_irq",  tb_irq,  m_tbf && m_tbie);
      chk(cap_irq == (m_capf && m_capie), "R6 cap_irq", cap_irq, m_capf && m_capie);
      chk(wdg_rst == m_rstp, "R5 wdg_rst", wdg_rst, m_rstp);
      chk(rdata == exp_rd, "R1/R7 rdata", rdata, exp_rd);
      if (wdg_rst) pulses++;
      if (tb_irq && !tb_prev) rise_t.push_back(cyc);
      tb_prev = tb_irq;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [7:0] d);
    sel = 1'b0; we = 1'b1; wd = d; step(); we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    sel = s; re = 1'b1; @(negedge clk); v = rdata; step(); re = 1'b0; sel = 1'b0;
  endtask

  task automatic wait_tb();
    logic [7:0] v;
    while (!tb_irq) step();
    rd(1'b0, v);
  endtask

  initial begin
    logic [7:0] v, a, b;
    int c0;
    step(4);
    rst_n = 1'b1;
    step(2);
    // R9 reset state
    chk(rdata == 8'h00 && !tb_irq && !cap_irq && !wdg_rst, "R9 ctrl/outputs", rdata, 0);
    sel = 1'b1; @(negedge clk);
    chk(rdata == 8'h00, "R9 capture byte", rdata, 0);
    step(); sel = 1'b0;

    // R2/R3 short period
    wr(8'h02);
    wait_tb(); wait_tb();
    chk(rise_t.size() == 2 && rise_t[1] - rise_t[0] == 8000, "R2 short period",
        rise_t.size() >= 2 ? rise_t[1] - rise_t[0] : -1, 8000);
    rd(1'b0, v);
    chk(v[2] == 1'b0, "R3 flag cleared by read", v[2], 0);
    // long period
    wr(8'h03);
    wait_tb(); rise_t.delete(); wait_tb(); wait_tb();
    chk(rise_t.size() == 2 && rise_t[1] - rise_t[0] == 16000, "R2 long period",
        rise_t.size() >= 2 ? rise_t[1] - rise_t[0] : -1, 16000);

    // R5 watchdog refreshed each period
    wr(8'h62);
    repeat (3) begin wait_tb(); wr(8'h62); end
    chk(pulses == 0, "R5 no reset while refreshed", pulses, 0);
    wait_tb();            // this period end consumes the last refresh
    wait_tb();            // this one finds the bit clear
    step(3);
    chk(pulses == 1, "R5 reset after missed refresh", pulses, 1);
    // R4 disabled
    wr(8'h02);
    wait_tb(); wait_tb();
    chk(pulses == 1, "R4 no reset when disabled", pulses, 1);

    // R6/R1 capture
    wr(8'h0A);
    pin = 1'b1; c0 = cyc;
    step(5);
    chk(cap_irq == 1'b1, "R6 capture irq", cap_irq, 1);
    rd(1'b1, a);
    rd(1'b0, v);
    chk(v[4] == 1'b0, "R7 flag cleared by capture read", v[4], 0);
    pin = 1'b0;
    wr(8'h1A);
    rd(1'b0, v);
    chk(v[4] == 1'b0, "R7 write cannot set flag", v[4], 0);
    while (cyc != c0 + 64) step();
    pin = 1'b1;
    step(5);
    rd(1'b1, b);
    chk(8'(b - a) == 8'd2, "R1 count rate", 8'(b - a), 2);
    pin = 1'b0;

    // R8 halt
    halt = 1'b1;
    step(4);
    pin = 1'b1; step(5); rd(1'b1, a); pin = 1'b0;
    step(200);
    pin = 1'b1; step(5); rd(1'b1, b); pin = 1'b0;
    chk(a == b, "R8 counter frozen in halt", b, a);
    halt = 1'b0;
    step(100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule